// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder for Flash Conversion

This block turns the comparator word of a flash converter into an N-bit binary code. The input has one bit per quantisation level, 2^N−1 bits in all, and bit 0 belongs to the lowest reference level. For a well-formed word, the output is the number of ones counted upward from bit 0.

The block does not count ones. It marks every level where a 1 sits directly under a 0, and it ORs the binary numbers of all marked levels into the result, in the way a wired-OR ROM with one row per transition would. A corrupted word with stray zeros or ones inside the run ("sparkle") therefore produces the OR of several codes rather than a corrected value. An optional flag reports when more than one transition is active.

The result, the flag and a valid strobe are registered on the rising clock edge. The output stage captures a new word only on cycles where the input strobe is high.

Top module: `therm_bin_enc`

## Requirements
- R1: With output width parameter CODE_W (default 4), the input word `th_in` is 2^CODE_W−1 bits wide and `out_code` is CODE_W bits wide, so the default build takes 15 bits and gives 4.
- R2: For a clean word (ones only in a contiguous run starting at bit 0), `out_code` equals the number of ones; for 7 bits, 0000011 gives 010 and 1111111 gives 111.
- R3: Level k (1 ≤ k ≤ 2^CODE_W−1) is a transition when input bit k−1 is 1 and bit k is 0, with the bit above the top bit taken as 0; an all-zero word has no transition and gives code 0.
- R4: When several transitions are active, `out_code` is the bitwise OR of their level numbers; the 15-bit word 000000010111111 (bit 14 on the left) gives 1110, while 000000011111111 gives 1000.
- R5: `out_sparkle` is 1 in the same cycle as the code it belongs to exactly when more than one transition was active; with SPARKLE_EN = 0 it stays 0.
- R6: `out_valid` equals `in_valid` delayed by one clock cycle.
- R7: `out_code` and `out_sparkle` are loaded only on a rising edge where `in_valid` is 1; otherwise they keep their value.
- R8: A rising edge with `rst_n` low clears `out_code`, `out_sparkle` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| th_in | input | 2^CODE_W−1 | Comparator word, bit 0 = lowest level |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_code | output | CODE_W | Registered binary code |
| out_sparkle | output | 1 | Registered flag: more than one transition |

## Verification
The bench builds two instances side by side. The default one (CODE_W = 4, flag on) is fed every one of the 32768 possible 15-bit words, so every clean code, every combination of multiple transitions and both ends of the range are covered, with hold cycles mixed in. A second instance with CODE_W = 3 and SPARKLE_EN = 0 receives the low seven bits of the same stream, which covers the narrow variant and the tied-off flag branch.

// File: rtl/therm_bin_enc_pkg.sv
// Package: shared helpers for the thermometer-to-binary encoder.
// Assumes: code widths are small (the word length grows as 2^N).
package therm_bin_enc_pkg;

    // Number of comparator bits needed for a code of n bits.
    function automatic int therm_width(input int n);
        return (1 << n) - 1;
    endfunction

endpackage

// File: rtl/therm_edge_detect.sv
// Module: therm_edge_detect
// Marks each level where a 1 lies directly under a 0 in the comparator word.
// trans_o[i] stands for level i+1. The bit above the top comparator is
// treated as 0, so a full word marks the top level.
// Assumes: purely combinational; no checking of the word's shape.
module therm_edge_detect #(
    parameter int TH_W = 15
) (
    input  logic [TH_W-1:0] th_i,
    output logic [TH_W-1:0] trans_o
);

    for (genvar i = 0; i < TH_W; i++) begin : g_lvl
        if (i == TH_W - 1) begin : g_top
            // Top level: nothing above it, so a 1 here is a transition.
            assign trans_o[i] = th_i[i];
        end else begin : g_mid
            // Inner level: 1 below, 0 above.
            assign trans_o[i] = th_i[i] & ~th_i[i+1];
        end
    end

endmodule

// File: rtl/therm_row_or.sv
// Module: therm_row_or
// Encodes the transition vector like a ROM with one row per level: every
// active row drives its level number, and all rows share wired-OR columns.
// Assumes: trans_i[k-1] belongs to level k; any number of rows may be active.
module therm_row_or #(
    parameter int CODE_W = 4,
    parameter int TH_W   = 15
) (
    input  logic [TH_W-1:0]   trans_i,
    output logic [CODE_W-1:0] code_o
);

    for (genvar b = 0; b < CODE_W; b++) begin : g_col
        logic col;

        // Column b collects every row whose level number has bit b set.
        always_comb begin
            col = 1'b0;
            for (int k = 1; k <= TH_W; k++) begin
                if (((k >> b) & 1) == 1) begin
                    col = col | trans_i[k-1];
                end
            end
        end

        assign code_o[b] = col;
    end

endmodule

// File: rtl/therm_multi_detect.sv
// Module: therm_multi_detect
// Raises multi_o when at least two bits of the transition vector are set.
// Uses a ripple chain of "one seen" and "two seen" flags from level 1 up.
// Assumes: purely combinational; TH_W >= 2.
module therm_multi_detect #(
    parameter int TH_W = 15
) (
    input  logic [TH_W-1:0] trans_i,
    output logic            multi_o
);

    logic [TH_W-1:0] seen;
    logic [TH_W-1:0] dup;

    for (genvar i = 0; i < TH_W; i++) begin : g_chain
        if (i == 0) begin : g_first
            // First link: a single bit cannot form a pair.
            assign seen[i] = trans_i[i];
            assign dup[i]  = 1'b0;
        end else begin : g_next
            // Later link: a pair exists if one was seen below and this is set.
            assign seen[i] = seen[i-1] | trans_i[i];
            assign dup[i]  = dup[i-1] | (seen[i-1] & trans_i[i]);
        end
    end

    assign multi_o = dup[TH_W-1];

endmodule

// File: rtl/therm_bin_enc.sv
// Module: therm_bin_enc (top)
// Flash-converter output encoder: transition detection, wired-OR row
// encoding, optional multi-transition flag, one output register stage.
// Assumes: th_in may be corrupted; no bubble correction is applied, so a
// corrupted word yields the OR of all transition codes.
module therm_bin_enc
    import therm_bin_enc_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter bit SPARKLE_EN = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [therm_width(CODE_W)-1:0]     th_in,
    output logic                               out_valid,
    output logic [CODE_W-1:0]                  out_code,
    output logic                               out_sparkle
);

    localparam int TH_W = therm_width(CODE_W);

    logic [TH_W-1:0]   trans;
    logic [CODE_W-1:0] code_d;
    logic              multi_d;

    therm_edge_detect #(.TH_W(TH_W)) u_edge (
        .th_i    (th_in),
        .trans_o (trans)
    );

    therm_row_or #(.CODE_W(CODE_W), .TH_W(TH_W)) u_rows (
        .trans_i (trans),
        .code_o  (code_d)
    );

    if (SPARKLE_EN) begin : g_flag
        therm_multi_detect #(.TH_W(TH_W)) u_multi (
            .trans_i (trans),
            .multi_o (multi_d)
        );

        // R5: the flag must follow the count of active transitions.
        assert_sparkle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_sparkle == ($past($countones(trans)) > 1)));
    end else begin : g_noflag
        assign multi_d = 1'b0;

        // R5: with the flag disabled it never rises.
        assert_sparkle_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !out_sparkle);
    end

    // Valid pipeline: one stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Result register: loads only with a valid word, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code    <= '0;
            out_sparkle <= 1'b0;
        end else if (in_valid) begin
            out_code    <= code_d;
            out_sparkle <= multi_d;
        end
    end

    // R3: some transition exists exactly when the word is non-zero.
    assert_trans_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((th_in != '0) == (trans != '0)));

    // R2: a clean word encodes to its count of ones.
    assert_clean_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((th_in & (th_in + 1'b1)) == '0))
        |=> (int'(out_code) == $countones($past(th_in))));

    // R6: strobe latency of exactly one cycle.
    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7: without a valid word the result does not move.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_code) && $stable(out_sparkle)));

    // R8: a reset edge leaves all outputs cleared.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_code == '0 && !out_sparkle));

endmodule

// File: tb/therm_bin_enc_bench.sv
`timescale 1ns/1ps
module therm_bin_enc_bench;

    localparam int NB  = 4;
    localparam int TH  = 15;
    localparam int NS  = 3;
    localparam int THS = 7;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           vin   = 1'b0;
    logic [TH-1:0]  th    = '0;
    logic [THS-1:0] th_s  = '0;
    logic           ov, osp, ov_s, osp_s;
    logic [NB-1:0]  oc;
    logic [NS-1:0]  oc_s;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    therm_bin_enc u_therm_bin_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .th_in(th),
        .out_valid(ov), .out_code(oc), .out_sparkle(osp)
    );

    therm_bin_enc #(.CODE_W(NS), .SPARKLE_EN(1'b0)) u_therm_bin_enc_small (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .th_in(th_s),
        .out_valid(ov_s), .out_code(oc_s), .out_sparkle(osp_s)
    );

    // Behavioural model: scan levels, OR level numbers, count transitions.
    function automatic int ref_code(input logic [TH-1:0] t, input int w, output int cnt);
        int c = 0;
        cnt = 0;
        for (int k = 1; k <= w; k++) begin
            bit above = (k == w) ? 1'b0 : t[k];
            if (t[k-1] && !above) begin
                c = c | k;
                cnt++;
            end
        end
        return c;
    endfunction

    int    m_code = 0, m_spark = 0, m_valid = 0, ms_code = 0;
    string m_tag  = "R8", ms_tag = "R8";

    // Reference state, advanced on each rising edge.
    always @(posedge clk) begin
        int cnt, cnt_s, c, cs;
        c  = ref_code(th, TH, cnt);
        cs = ref_code({8'b0, th_s}, THS, cnt_s);
        if (!rst_n) begin
            m_code <= 0; m_spark <= 0; m_valid <= 0; ms_code <= 0;
            m_tag <= "R8"; ms_tag <= "R8";
        end else begin
            m_valid <= vin;
            if (vin) begin
                m_code  <= c;
                m_spark <= (cnt > 1);
                ms_code <= cs;
                m_tag   <= (cnt > 1) ? "R4" : (cnt == 0 ? "R3" : "R2");
                ms_tag  <= (cnt_s > 1) ? "R4" : (cnt_s == 0 ? "R3" : "R2");
            end else begin
                m_tag  <= "R7";
                ms_tag <= "R7";
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare at the falling edge, then drive the next stimulus.
    task automatic step(input logic [TH-1:0] t, input logic v);
        @(negedge clk);
        check(m_tag, int'(oc), m_code);
        check({m_tag == "R7" ? "R7" : "R5"}, int'(osp), m_spark);
        check(m_valid ? "R6" : "R6/R8", int'(ov), m_valid);
        check(ms_tag, int'(oc_s), ms_code);
        check("R5", int'(osp_s), 0);
        check("R6", int'(ov_s), m_valid);
        th   = t;
        th_s = t[THS-1:0];
        vin  = v;
    endtask

    initial begin
        step('0, 1'b0);
        step('0, 1'b1);      // R8: reset still low, valid ignored
        rst_n = 1'b1;

        // R1: port widths of the default build.
        check("R1", $bits(th), TH);
        check("R1", $bits(oc), NB);

        // R2: every clean word.
        for (int k = 0; k <= TH; k++) step(TH'((1 << k) - 1), 1'b1);
        // R4: documented corrupted word and its clean neighbour.
        step(15'b000000010111111, 1'b1);
        step(15'b000000011111111, 1'b1);
        step(15'b101010101010101, 1'b1);
        // R7: holds while the strobe is low.
        step(15'b000000000000111, 1'b0);
        step(15'b111111111111111, 1'b0);
        // R8: reset in the middle of operation.
        step(15'b010101010101011, 1'b1);
        rst_n = 1'b0;
        step(15'b000000000001111, 1'b1);
        rst_n = 1'b1;
        // R2..R7: every possible word, with gaps in the strobe.
        for (int i = 0; i < (1 << TH); i++) step(TH'(i), (i % 7) != 3);
        step('0, 1'b0);
        step('0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule